// File: doc/BRIEF.md
# Pointer-Redirect Survivor Path Unit

This block manages survivor paths for a Viterbi decoder. Each accepted step brings one decision bit per trellis state from the add-compare-select array. Every state owns a pointer to a physical history row. When a path extends, the state's pointer is steered to the row of the predecessor it chose, and only the newest column is written. Nothing is shifted, and whole rows are not moved from state to state. The caller also supplies the index of the currently best state. The block returns the oldest bit of that state's history, so decoded bits leave in natural time order at the data rate.

When two states of a butterfly pick the same predecessor, the other predecessor of that butterfly has no successor left. Its row is therefore free and is handed to the second state, which receives a copy of the shared history. The free row is always found inside the same butterfly, so no search over all rows is needed. A parameter selects a reduced single-row form for an encoder whose start state is known to be zero. In that form the history is two bits deep and is driven by the best state alone.

Top module: `svu_ptr`

## Requirements
- R1: A synchronous active-high `rst` clears every history row to zero, restores the identity pointer map and clears the step count. `out_valid` is low in the cycle that follows any edge at which `rst` was high.
- R2: Bit s of `dec_bits` picks the predecessor of state s. A value of 0 selects s>>1 and a value of 1 selects (s>>1)+2^(K-2). The history of s becomes the predecessor's history with s[0] appended as the newest bit.
- R3: `out_valid` is high only in the cycle after an edge that accepted `dec_valid`, and only once DEPTH steps have been accepted since reset.
- R4: `out_bit` is the bit of the `best_state` history that was appended DEPTH-1 steps before the current step, so bits leave oldest first in time order.
- R5: When both states of a butterfly (states 2j and 2j+1) select the same predecessor, both end up with correct histories.
- R6: Each history row is referenced by exactly one state pointer at every cycle.
- R7: A cycle with `dec_valid` low changes no history and produces no output.
- R8: With ONE_ROW=1, `out_valid` rises once two steps have been accepted, and `out_bit` equals bit 0 of the `best_state` given with the previous accepted step.
- R9: When `best_state` tracks the true encoder state and that state's decision is correct, step t outputs the message bit of step t-DEPTH+1. In the single-row form it outputs the message bit of step t-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decision vector strobe |
| dec_bits | input | 2^(K-1) | One predecessor-select bit per state |
| best_state | input | K-1 | Index of the best state after this step |
| out_valid | output | 1 | Decoded bit strobe |
| out_bit | output | 1 | Decoded bit, oldest first |

## Verification
The bench first drives a table of mixed decision vectors with a varying best state. It compares the output against a copying shift-history model, which shows whether pointer steering gives the same paths as moving row contents. It then drives runs of all-zero and all-one decisions. These make every butterfly collide, so the free-row handoff is exercised and any broken copy on collision shows up. Idle gaps and a reset in mid-stream separate held state from cleared state. Finally, a message encoded along a true path, mixed with noisy decisions elsewhere, shows that the decoded stream reproduces the message with the intended delay in both the full form and the single-row form.

// File: rtl/svu_ptr.sv
module svu_ptr #(
  parameter int K       = 9,
  parameter int DEPTH   = 5 * (K - 1),
  parameter int ONE_ROW = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dec_valid,
  input  logic [(1<<(K-1))-1:0]   dec_bits,
  input  logic [K-2:0]            best_state,
  output logic                    out_valid,
  output logic                    out_bit
);
  localparam int NS   = 1 << (K - 1);
  localparam int SW   = K - 1;
  localparam int HALF = NS / 2;
  localparam int LIM  = (ONE_ROW != 0) ? 2 : DEPTH;
  localparam int CNTW = $clog2(LIM + 1);
  localparam int CW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic            pend;
  logic [CNTW-1:0] cnt;
  logic [NS-1:0]   row_owned;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      cnt  <= '0;
    end else begin
      pend <= dec_valid;
      if (dec_valid && cnt != CNTW'(LIM)) cnt <= cnt + 1'b1;
    end
  end

  assign out_valid = pend && (cnt == CNTW'(LIM));

  generate
    if (ONE_ROW != 0) begin : g_one
      logic [1:0] line;
      always_ff @(posedge clk) begin
        if (rst) line <= '0;
        else if (dec_valid) line <= {line[0], best_state[0]};
      end
      assign out_bit   = line[1];
      assign row_owned = '1;
    end else begin : g_ptr
      logic [SW-1:0]    ptr  [NS];
      logic [SW-1:0]    nptr [NS];
      logic [DEPTH-1:0] mem  [NS];
      logic [DEPTH-1:0] nmem [NS];
      logic [CW-1:0]    col;
      logic [SW-1:0]    best_q;
      logic             da, db;
      logic [SW-1:0]    ra, rb;

      always_comb begin
        nptr = ptr;
        nmem = mem;
        da = 1'b0; db = 1'b0; ra = '0; rb = '0;
        for (int j = 0; j < HALF; j++) begin
          da = dec_bits[2*j];
          db = dec_bits[2*j+1];
          ra = da ? ptr[j+HALF] : ptr[j];
          if (da == db) rb = da ? ptr[j] : ptr[j+HALF];
          else          rb = db ? ptr[j+HALF] : ptr[j];
          nptr[2*j]   = ra;
          nptr[2*j+1] = rb;
          if (da == db) nmem[rb] = mem[ra];
          nmem[ra][col] = 1'b0;
          nmem[rb][col] = 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < NS; s++) begin
            ptr[s] <= SW'(s);
            mem[s] <= '0;
          end
          col    <= '0;
          best_q <= '0;
        end else if (dec_valid) begin
          ptr    <= nptr;
          mem    <= nmem;
          col    <= (col == CW'(DEPTH - 1)) ? '0 : col + 1'b1;
          best_q <= best_state;
        end
      end

      assign out_bit = mem[ptr[best_q]][col];

      always_comb begin
        row_owned = '0;
        for (int s = 0; s < NS; s++) row_owned[ptr[s]] = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/svu_ptr_chk.sv
module svu_ptr_chk #(
  parameter int NS  = 256,
  parameter int LIM = 40
) (
  input logic          clk,
  input logic          rst,
  input logic          dec_valid,
  input logic          out_valid,
  input logic [NS-1:0] row_owned
);
  localparam int SCW = $clog2(LIM + 1);
  logic [SCW-1:0] steps;

  always_ff @(posedge clk) begin
    if (rst) steps <= '0;
    else if (dec_valid && steps != SCW'(LIM)) steps <= steps + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R3
  valid_follows_step_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(dec_valid));

  // R3
  no_early_output_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> steps == SCW'(LIM));

  // R6
  row_unique_chk: assert property (@(posedge clk) disable iff (rst)
    row_owned == '1);

  // R7
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> !out_valid);
endmodule

bind svu_ptr svu_ptr_chk #(.NS(NS), .LIM(LIM)) u_chk (
  .clk(clk), .rst(rst), .dec_valid(dec_valid),
  .out_valid(out_valid), .row_owned(row_owned)
);

// File: tb/svu_ptr_tb.sv
`timescale 1ns/100ps
module svu_ptr_tb;
  localparam int KT = 4;
  localparam int DT = 6;
  localparam int NT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_valid = 1'b0;
  logic [NT-1:0] dec_bits = '0;
  logic [KT-2:0] best_state = '0;
  logic out_valid, out_bit, ov1, ob1;

  int n_tests = 0;
  int n_fail  = 0;

  logic [DT-1:0] hist [NT];
  int   steps;
  logic o0, o1;
  int   c1;
  logic [15:0] lfsr;

  localparam logic [10:0] VEC [16] = '{
    11'h1A5, 11'h3C2, 11'h0F7, 11'h6E1, 11'h233, 11'h7FF, 11'h000, 11'h4D6,
    11'h59C, 11'h12B, 11'h6A4, 11'h38F, 11'h7B0, 11'h0C5, 11'h29E, 11'h51D
  };

  always #2.5 clk = ~clk;

  svu_ptr #(.K(KT), .DEPTH(DT), .ONE_ROW(0)) u_dut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_bits(dec_bits),
    .best_state(best_state), .out_valid(out_valid), .out_bit(out_bit));

  svu_ptr #(.K(KT), .DEPTH(DT), .ONE_ROW(1)) u_dut_one (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_bits(dec_bits),
    .best_state(best_state), .out_valid(ov1), .out_bit(ob1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NT; s++) hist[s] = '0;
    steps = 0; o0 = 1'b0; o1 = 1'b0; c1 = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1; dec_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_clear();
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(ov1 == 1'b0, "R1 reset out_valid one-row", ov1, 0);
    rst = 1'b0;
  endtask

  task automatic step(input logic v, input logic [NT-1:0] d, input logic [KT-2:0] b, input string tag);
    logic [DT-1:0] nh [NT];
    logic ev, eb, ev1, eb1;
    dec_valid = v; dec_bits = d; best_state = b;
    @(negedge clk);
    ev = 1'b0; eb = 1'b0; ev1 = 1'b0; eb1 = 1'b0;
    if (v) begin
      for (int s = 0; s < NT; s++) begin
        int p;
        p = (s >> 1) | (int'(d[s]) << (KT - 2));
        nh[s] = {hist[p][DT-2:0], s[0]};
      end
      for (int s = 0; s < NT; s++) hist[s] = nh[s];
      if (steps < DT) steps++;
      ev = (steps == DT);
      eb = hist[b][DT-1];
      o1 = o0; o0 = b[0];
      if (c1 < 2) c1++;
      ev1 = (c1 == 2);
      eb1 = o1;
    end
    chk(out_valid == ev, {tag, " out_valid"}, out_valid, ev);
    if (ev) chk(out_bit == eb, {tag, " out_bit"}, out_bit, eb);
    chk(ov1 == ev1, {tag, " R8 out_valid"}, ov1, ev1);
    if (ev1) chk(ob1 == eb1, {tag, " R8 out_bit"}, ob1, eb1);
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog timeout");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [NT-1:0] d;
    logic [KT-2:0] ts, prev;
    logic u;
    logic msg [64];
    model_clear();
    @(negedge clk);
    // R1: reset state
    do_reset();

    // R2 R3 R4: table of mixed decision vectors
    for (int i = 0; i < 16; i++)
      step(1'b1, VEC[i][10:3], VEC[i][2:0], "R2 R3 R4 table");

    // R7: idle cycles hold state and stay silent
    for (int i = 0; i < 3; i++) step(1'b0, 8'hA5, 3'd6, "R7 idle");
    for (int i = 0; i < 4; i++) step(1'b1, VEC[i][10:3], VEC[15-i][2:0], "R7 resume");

    // R5 R6: every butterfly collides
    do_reset();
    for (int i = 0; i < 12; i++)
      step(1'b1, (i % 3 == 2) ? 8'hFF : 8'h00, 3'(i * 5), "R5 R6 collide");

    // R1: reset mid-stream clears histories
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b1, 8'hFF, 3'd7, "R1 after reset");

    // R9: true encoder path with noisy other decisions
    do_reset();
    lfsr = 16'hACE1; ts = '0;
    for (int i = 0; i < 40; i++) begin
      lfsr = nxt(lfsr);
      u = lfsr[0];
      prev = ts;
      ts = {ts[KT-3:0], u};
      d = lfsr[15:8];
      d[ts] = prev[KT-2];
      msg[i] = u;
      step(1'b1, d, ts, "R9 path");
      if (i >= DT - 1) chk(out_bit == msg[i-DT+1], "R9 decoded bit", out_bit, msg[i-DT+1]);
      if (i >= 1) chk(ob1 == msg[i-1], "R9 R8 decoded bit one-row", ob1, msg[i-1]);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule